// File: doc/BRIEF.md
# Packed 16-bit Word Shuffle Unit

This execution unit rearranges the 16-bit lanes of a vector operand. An 8-bit immediate holds four 2-bit selectors. Selector k names the source lane that fills destination lane k of the shuffled group. A 2-bit mode picks which group is shuffled. In the upper-half mode, the four upper lanes of a 128-bit value are permuted and the lower 64 bits pass through. In the lower-half mode, the four lower lanes are permuted and the upper 64 bits pass through. In the standalone 64-bit mode, all four lanes of a 64-bit operand are permuted.

One operation can be accepted on every clock. The result is registered and appears one cycle after the request, together with its own valid strobe. When no request arrives, the registered result is held. The unit sets no flags and signals no exceptions.

The mode input is decoded as four named cases:

| Mode code | Name | Behaviour |
|---|---|---|
| 2'b00 | MODE_W64 | 64-bit operand, all four lanes permuted |
| 2'b01 | MODE_LO | lower-half shuffle |
| 2'b10 | MODE_HI | upper-half shuffle |
| 2'b11 | MODE_LO_ALT | same as lower-half shuffle |

The unit has no states and no transitions. Its only storage is the result register, which captures on a valid request and holds otherwise.

Top module: `wsh_shuffle_unit`

## Requirements
- R1: In the first cycle after synchronous reset, out_valid is 0 and out_data is all zeros.
- R2: out_valid equals in_valid delayed by exactly one clock.
- R3: Immediate bits [2k+1:2k] (k = 0..3) select the source lane placed in destination lane k of the shuffled group. Each selector is a binary lane index from 0 to 3 within the group.
- R4: With mode 2'b10, destination lane 4+k is source lane 4+sel_k. Destination bits [63:0] equal source bits [63:0].
- R5: With mode 2'b01, destination lane k is source lane sel_k. Destination bits [127:64] equal source bits [127:64].
- R6: With mode 2'b00, destination lane k is source lane sel_k taken from bits [63:0]. Result bits [127:64] are zero, and source bits [127:64] have no effect on the result.
- R7: Mode 2'b11 produces exactly the same result as mode 2'b01.
- R8: One source lane may fill several destination lanes. Immediate 0x00 broadcasts lane 0 (lane 4 in mode 2'b10), and 0xFF broadcasts lane 3 (lane 7 in mode 2'b10).
- R9: In a cycle after in_valid was 0, out_data keeps its previous value, whatever in_mode, in_src and in_imm carried.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Request strobe |
| in_mode | input | 2 | Shuffle mode: 00 64-bit, 01 lower half, 10 upper half, 11 lower half |
| in_src | input | 128 | Source vector, lane k at bits [16k+15:16k] |
| in_imm | input | 8 | Four 2-bit lane selectors |
| out_valid | output | 1 | Result strobe, one cycle after in_valid |
| out_data | output | 128 | Registered shuffle result |

## Verification
Two events can fall in the same cycle: a result is launched at the output, and in_valid drops while the inputs change to unrelated values. In that cycle the register must hold the last result and must not capture the new inputs. The random stream puts gaps at random spots between valid requests and varies mode, source and immediate during the gaps. Each cycle the bench compares out_valid against the delayed request. It compares out_data against a lane-level model of the last accepted request, so a capture during a gap shows up as a miscompare.

// File: rtl/wsh_pkg.sv
package wsh_pkg;
    // Default geometry: 16-bit lanes, four lanes per shuffled group.
    parameter int WSH_WORD_W      = 16;
    parameter int WSH_GROUP_WORDS = 4;

    // Shuffle mode encoding; code 2'b11 is an alias of the lower-half form.
    typedef enum logic [1:0] {
        MODE_W64    = 2'b00,
        MODE_LO     = 2'b01,
        MODE_HI     = 2'b10,
        MODE_LO_ALT = 2'b11
    } wsh_mode_e;
endpackage

// File: rtl/wsh_word_pick.sv
module wsh_word_pick #(
    parameter int WORD_W  = 16,
    parameter int N_WORDS = 4,
    localparam int SEL_W  = $clog2(N_WORDS),
    localparam int GRP_W  = WORD_W * N_WORDS
) (
    input  logic [GRP_W-1:0]  grp,
    input  logic [SEL_W-1:0]  sel,
    output logic [WORD_W-1:0] word
);
    // One lane multiplexer: chooses lane 'sel' of the group.
    always_comb begin
        word = grp[sel*WORD_W +: WORD_W];
    end
endmodule

// File: rtl/wsh_permute.sv
module wsh_permute
    import wsh_pkg::*;
#(
    parameter int WORD_W      = 16,
    parameter int GROUP_WORDS = 4,
    localparam int SEL_W      = $clog2(GROUP_WORDS),
    localparam int GROUP_W    = WORD_W * GROUP_WORDS,
    localparam int DATA_W     = 2 * GROUP_W,
    localparam int IMM_W      = GROUP_WORDS * SEL_W
) (
    input  wsh_mode_e         mode,
    input  logic [DATA_W-1:0] src,
    input  logic [IMM_W-1:0]  imm,
    output logic [DATA_W-1:0] res
);
    logic [GROUP_W-1:0] lo_grp;
    logic [GROUP_W-1:0] hi_grp;
    logic [GROUP_W-1:0] pick_grp;
    logic [GROUP_W-1:0] picked;

    assign lo_grp = src[GROUP_W-1:0];
    assign hi_grp = src[DATA_W-1:GROUP_W];

    // Only the upper-half form draws lanes from the upper group.
    always_comb begin
        unique case (mode)
            MODE_HI:                       pick_grp = hi_grp;
            MODE_W64, MODE_LO, MODE_LO_ALT: pick_grp = lo_grp;
        endcase
    end

    // One lane multiplexer per destination lane of the group.
    for (genvar k = 0; k < GROUP_WORDS; k++) begin : g_lane
        wsh_word_pick #(
            .WORD_W  (WORD_W),
            .N_WORDS (GROUP_WORDS)
        ) u_pick (
            .grp  (pick_grp),
            .sel  (imm[k*SEL_W +: SEL_W]),
            .word (picked[k*WORD_W +: WORD_W])
        );
    end

    // Put the permuted group beside the pass-through or zero half.
    always_comb begin
        unique case (mode)
            MODE_W64:             res = {{GROUP_W{1'b0}}, picked};
            MODE_HI:              res = {picked, lo_grp};
            MODE_LO, MODE_LO_ALT: res = {hi_grp, picked};
        endcase
    end
endmodule

// File: rtl/wsh_out_reg.sv
module wsh_out_reg #(
    parameter int DATA_W = 128
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] in_data,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_data
);
    // Valid strobe register.
    always_ff @(posedge clk) begin
        if (rst) out_valid <= 1'b0;
        else     out_valid <= in_valid;
    end

    // Result register: captures on a request, holds otherwise.
    always_ff @(posedge clk) begin
        if (rst)           out_data <= '0;
        else if (in_valid) out_data <= in_data;
    end
endmodule

// File: rtl/wsh_shuffle_unit.sv
module wsh_shuffle_unit
    import wsh_pkg::*;
#(
    parameter int WORD_W      = WSH_WORD_W,
    parameter int GROUP_WORDS = WSH_GROUP_WORDS,
    localparam int SEL_W      = $clog2(GROUP_WORDS),
    localparam int GROUP_W    = WORD_W * GROUP_WORDS,
    localparam int DATA_W     = 2 * GROUP_W,
    localparam int IMM_W      = GROUP_WORDS * SEL_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [1:0]        in_mode,
    input  logic [DATA_W-1:0] in_src,
    input  logic [IMM_W-1:0]  in_imm,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_data
);
    wsh_mode_e         mode;
    logic [DATA_W-1:0] shuf;

    assign mode = wsh_mode_e'(in_mode);

    wsh_permute #(
        .WORD_W      (WORD_W),
        .GROUP_WORDS (GROUP_WORDS)
    ) u_perm (
        .mode (mode),
        .src  (in_src),
        .imm  (in_imm),
        .res  (shuf)
    );

    wsh_out_reg #(
        .DATA_W (DATA_W)
    ) u_oreg (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .in_data   (shuf),
        .out_valid (out_valid),
        .out_data  (out_data)
    );
endmodule

// File: rtl/wsh_shuffle_chk.sv
module wsh_shuffle_chk #(
    parameter int WORD_W      = 16,
    parameter int GROUP_WORDS = 4,
    localparam int SEL_W      = $clog2(GROUP_WORDS),
    localparam int GROUP_W    = WORD_W * GROUP_WORDS,
    localparam int DATA_W     = 2 * GROUP_W,
    localparam int IMM_W      = GROUP_WORDS * SEL_W
) (
    input logic              clk,
    input logic              rst,
    input logic              in_valid,
    input logic [1:0]        in_mode,
    input logic [DATA_W-1:0] in_src,
    input logic [IMM_W-1:0]  in_imm,
    input logic              out_valid,
    input logic [DATA_W-1:0] out_data
);
    assert_valid_rise_R2: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);

    assert_valid_idle_R2: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);

    assert_hi_passthru_R4: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_mode == 2'b10) |=>
            out_data[GROUP_W-1:0] == $past(in_src[GROUP_W-1:0]));

    assert_lo_passthru_R5: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_mode[1] == 1'b0 && in_mode[0] == 1'b1) |=>
            out_data[DATA_W-1:GROUP_W] == $past(in_src[DATA_W-1:GROUP_W]));

    assert_w64_upper_zero_R6: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_mode == 2'b00) |=>
            out_data[DATA_W-1:GROUP_W] == '0);

    assert_alias_passthru_R7: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_mode == 2'b11) |=>
            out_data[DATA_W-1:GROUP_W] == $past(in_src[DATA_W-1:GROUP_W]));

    assert_lo_broadcast_R8: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_mode == 2'b01 && in_imm == '0) |=>
            out_data[2*WORD_W-1:WORD_W] == $past(in_src[WORD_W-1:0]));

    assert_idle_hold_R9: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> $stable(out_data));
endmodule

bind wsh_shuffle_unit wsh_shuffle_chk #(
    .WORD_W      (WORD_W),
    .GROUP_WORDS (GROUP_WORDS)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .in_mode   (in_mode),
    .in_src    (in_src),
    .in_imm    (in_imm),
    .out_valid (out_valid),
    .out_data  (out_data)
);

// File: tb/tb_wsh_shuffle_unit.sv
`timescale 1ns/1ps
module tb_wsh_shuffle_unit;
    logic         clk = 1'b0;
    logic         rst;
    logic         in_valid;
    logic [1:0]   in_mode;
    logic [127:0] in_src;
    logic [7:0]   in_imm;
    logic         out_valid;
    logic [127:0] out_data;

    int n_chk  = 0;
    int n_fail = 0;
    logic [127:0] exp_data;

    always #4 clk = ~clk;

    wsh_shuffle_unit dut (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .in_mode   (in_mode),
        .in_src    (in_src),
        .in_imm    (in_imm),
        .out_valid (out_valid),
        .out_data  (out_data)
    );

    // Lane-level model written from the requirements.
    function automatic logic [127:0] model(input logic [1:0] m,
                                           input logic [127:0] s,
                                           input logic [7:0] im);
        logic [127:0] r;
        int sel;
        r = s;
        if (m == 2'b00) r[127:64] = '0;
        for (int k = 0; k < 4; k++) begin
            sel = int'(im[2*k +: 2]);
            if (m == 2'b10) r[64 + 16*k +: 16] = s[64 + 16*sel +: 16];
            else            r[16*k +: 16]      = s[16*sel +: 16];
        end
        return r;
    endfunction

    task automatic check_out(input logic ev, input string tag);
        n_chk++;
        if (out_valid !== ev || out_data !== exp_data) begin
            n_fail++;
            $display("FAIL %s: valid=%0b data=%h expected valid=%0b data=%h",
                     tag, out_valid, out_data, ev, exp_data);
        end
    endtask

    // Called at a falling edge; checks the result one cycle later.
    task automatic step(input logic v, input logic [1:0] m,
                        input logic [127:0] s, input logic [7:0] im,
                        input string tag);
        in_valid = v; in_mode = m; in_src = s; in_imm = im;
        @(negedge clk);
        if (v) exp_data = model(m, s, im);
        check_out(v, tag);
    endtask

    function automatic logic [127:0] rnd128();
        return {$urandom, $urandom, $urandom, $urandom};
    endfunction

    localparam logic [127:0] PAT = 128'h7777_6666_5555_4444_3333_2222_1111_0000;

    initial begin
        #(8 * 200000);
        n_fail++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'h5eed_0123));
        rst = 1'b1; in_valid = 1'b0; in_mode = 2'b00; in_src = '0; in_imm = '0;
        exp_data = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        check_out(1'b0, "R1 reset state");

        // R3: reversal 0x1B shows each field drives its own lane.
        step(1'b1, 2'b01, PAT, 8'h1B, "R3 field order");
        // R3: identity 0xE4.
        step(1'b1, 2'b01, PAT, 8'hE4, "R3 identity");
        // R4: upper-half reversal.
        step(1'b1, 2'b10, PAT, 8'h1B, "R4 upper half");
        // R5: lower-half rotate.
        step(1'b1, 2'b01, PAT, 8'h39, "R5 lower half");
        // R6: 64-bit form, upper source junk must not show.
        step(1'b1, 2'b00, {64'hDEAD_BEEF_CAFE_F00D, PAT[63:0]}, 8'h4E, "R6 64-bit form");
        step(1'b1, 2'b00, {64'h0123_4567_89AB_CDEF, PAT[63:0]}, 8'h4E, "R6 upper ignored");
        // R7: alias code.
        step(1'b1, 2'b11, PAT, 8'h93, "R7 mode 11 alias");
        // R8: broadcasts.
        step(1'b1, 2'b01, PAT, 8'h00, "R8 broadcast lane 0");
        step(1'b1, 2'b10, PAT, 8'h00, "R8 broadcast lane 4");
        step(1'b1, 2'b10, PAT, 8'hFF, "R8 broadcast lane 7");
        step(1'b1, 2'b00, PAT, 8'hFF, "R8 broadcast lane 3");
        // R9: idle cycle with changed inputs must hold.
        step(1'b0, 2'b10, rnd128(), 8'h5A, "R9 hold on idle");
        step(1'b0, 2'b00, rnd128(), 8'hC3, "R9 hold second idle");
        // R2: back-to-back then idle.
        step(1'b1, 2'b01, rnd128(), 8'h72, "R2 restart");

        // Random stream with gaps (R2, R4-R7, R9).
        for (int i = 0; i < 600; i++) begin
            logic v;
            v = ($urandom % 4) != 0;
            step(v, 2'($urandom), rnd128(), 8'($urandom),
                 v ? "R2 R4 R5 R6 R7 random" : "R9 random idle");
        end

        // R1: reset in mid-stream clears the outputs.
        in_valid = 1'b1; rst = 1'b1;
        @(negedge clk);
        rst = 1'b0; in_valid = 1'b0;
        exp_data = '0;
        check_out(1'b0, "R1 reset mid-stream");

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule